// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down-counters behind a small byte-wide processor bus. Two address lines pick counter 0, 1 or 2, or the shared control register at address 3. Software first writes a control byte that names a channel, says how the count is transferred (low byte, high byte, or low then high), and picks one of six counting modes. It then writes the count through the channel's own address. Each channel has a count-clock enable, a GATE input and an OUT output. The enable is sampled on the common clock and stands in for a separate count clock. Depending on the mode, OUT gives a terminal-count flag, a retriggerable one-shot, a divide-by-N pulse train, a square wave, or a single-tick strobe.

A read from a channel address returns one byte of that channel's live counting register. The channel's transfer setting picks which byte is returned.

Top module: `pit_timer3`

## Requirements
- R1: Control byte fields are: bits 7:6 channel, bits 5:4 transfer (01 low only, 10 high only, 11 low then high), bits 3:1 mode (6 and 7 alias modes 2 and 3), bit 0 ignored. 36H therefore sets channel 0 to square wave with a two-byte count, 54H sets channel 1 to rate mode with a low-byte count, and B6H sets channel 2 to square wave with a two-byte count.
- R2: A control byte with channel field 11 or transfer field 00 changes nothing, and a running channel keeps its waveform.
- R3: After reset every OUT is low and no channel counts. A control byte stops its channel, sets OUT low for mode 0 and high for every other mode, and the channel waits for a count.
- R4: In two-byte transfer the first data write is held and the count takes effect on the second. A low-only count has zero in its upper byte, and a high-only count has zero in its lower byte.
- R5: Mode 0: on load OUT goes low, stays low for N count ticks, then goes high and stays high.
- R6: Mode 1: after load OUT stays high until a GATE rising edge. OUT is then low for N ticks. A further rising edge during the pulse restarts the N ticks.
- R7: Mode 2: OUT repeats a cycle of N−1 ticks high and 1 tick low.
- R8: Mode 3: OUT is high for ceil(N/2) ticks and low for floor(N/2) ticks, repeatedly.
- R9: Mode 4: counting starts at load. OUT stays high for N ticks, is low for one tick, then stays high.
- R10: Mode 5: the same waveform as mode 4, but a GATE rising edge starts it.
- R11: A count of 0 acts as 65536.
- R12: A read returns the live count byte. In two-byte transfer, reads alternate low then high, and each control byte restarts the order at low.
- R13: Counting advances only on clock edges where the channel's tick is high. In modes 0, 2, 3 and 4 it also needs GATE high. In modes 2 and 3, GATE low forces OUT high, and a GATE rising edge restarts the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one clock |
| rd_en | input | 1 | Read strobe for one clock |
| addr | input | 2 | 0 to 2 select a channel, 3 selects the control register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational while rd_en is high, zero otherwise |
| tick | input | 3 | Per-channel count-clock enable |
| gate | input | 3 | Per-channel GATE |
| out | output | 3 | Per-channel OUT |

## Verification
Most internal faults show up as a wrong run length on OUT, so the bench measures how many ticks each OUT level lasts and compares that with the N that was written. A wrong half-period length, reload point or strobe exit changes a run by one tick within the first period. A decode fault that sends a control byte to the wrong place stops a running channel, and OUT then holds its idle level and never returns to the other level. A fault in the byte-order flip-flop gives a count that is off by a factor of 256, or a read whose two bytes come back swapped. Each of these shows on the very next read.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int MODE_W = 3;

  localparam logic [1:0] ACC_LO   = 2'b01;
  localparam logic [1:0] ACC_HI   = 2'b10;
  localparam logic [1:0] ACC_BOTH = 2'b11;

  localparam logic [MODE_W-1:0] M_TERM    = 3'd0;
  localparam logic [MODE_W-1:0] M_ONESHOT = 3'd1;
  localparam logic [MODE_W-1:0] M_RATE    = 3'd2;
  localparam logic [MODE_W-1:0] M_SQUARE  = 3'd3;
  localparam logic [MODE_W-1:0] M_SWSTB   = 3'd4;
  localparam logic [MODE_W-1:0] M_HWSTB   = 3'd5;

  typedef enum logic [2:0] {
    ST_WAIT, ST_ARMED, ST_RUN, ST_STROBE, ST_DONE
  } chan_st_e;

  // Modes 6 and 7 fold onto 2 and 3.
  function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] f);
    return (f[2] && f[1]) ? {1'b0, f[1:0]} : f;
  endfunction

  // Effective division ratio: zero stands for the full 2^CNT_W span.
  function automatic logic [CNT_W:0] span_of(input logic [CNT_W-1:0] n);
    return (n == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, n};
  endfunction

  function automatic logic [CNT_W-1:0] sq_high_len(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] s;
    s = span_of(n) + (CNT_W+1)'(1);
    return CNT_W'(s >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] sq_low_len(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] s;
    s = span_of(n);
    return CNT_W'(s >> 1);
  endfunction
endpackage

// File: rtl/pit_decode.sv
module pit_decode
  import pit_pkg::*;
#(
  parameter int CHANNELS = 3,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:1]   cw_field,
  output logic [CHANNELS-1:0] cw_wr,
  output logic [CHANNELS-1:0] data_wr,
  output logic [CHANNELS-1:0] rd_stb,
  output logic [1:0]          cw_acc,
  output logic [MODE_W-1:0]   cw_mode
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

  logic       is_ctrl;
  logic [1:0] sel;
  logic       cw_valid;

  assign is_ctrl  = (addr == CTRL_ADDR);
  assign sel      = cw_field[7:6];
  assign cw_acc   = cw_field[5:4];
  assign cw_mode  = fold_mode(cw_field[3:1]);
  assign cw_valid = wr_en && is_ctrl && (cw_acc != 2'b00);

  for (genvar i = 0; i < CHANNELS; i++) begin : g_sel
    assign cw_wr[i]   = cw_valid && (sel == 2'(i));
    assign data_wr[i] = wr_en && (addr == ADDR_W'(i));
    assign rd_stb[i]  = rd_en && (addr == ADDR_W'(i));
  end

  // R1: one write reaches at most one target
  assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cw_wr, data_wr}));
  // R2: reserved channel field or latch transfer code reaches nobody
  assert_reserved_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_ctrl && (sel == 2'b11 || cw_field[5:4] == 2'b00)) |-> (cw_wr == '0));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_wr,
  input  logic [1:0]        cw_acc,
  input  logic [MODE_W-1:0] cw_mode,
  input  logic              data_wr,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic              gate,
  output logic              out,
  output logic [DATA_W-1:0] rd_byte
);
  logic [MODE_W-1:0] mode_q;
  logic [1:0]        acc_q;
  chan_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q, reload_q, new_count;
  logic [DATA_W-1:0] lo_hold_q;
  logic              wr_hi_q, rd_hi_q, gate_q, out_q;

  // Named events for the assertions
  logic load_fire, gate_rise, retrig, gate_ok, advance, hold_high, periodic, edge_mode;

  assign load_fire = data_wr && (acc_q != ACC_BOTH || wr_hi_q);
  assign gate_rise = gate && !gate_q;
  assign periodic  = (mode_q == M_RATE) || (mode_q == M_SQUARE);
  assign edge_mode = (mode_q == M_ONESHOT) || (mode_q == M_HWSTB);
  assign retrig    = gate_rise && (st_q != ST_WAIT) && (periodic || edge_mode);
  assign gate_ok   = edge_mode || gate;
  assign advance   = tick && gate_ok && (st_q == ST_RUN || st_q == ST_STROBE);
  assign hold_high = periodic && (st_q == ST_RUN) && !gate;

  always_comb begin
    unique case (acc_q)
      ACC_LO:  new_count = {{DATA_W{1'b0}}, wdata};
      ACC_HI:  new_count = {wdata, {DATA_W{1'b0}}};
      default: new_count = {wdata, lo_hold_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_TERM;
      acc_q     <= ACC_BOTH;
      st_q      <= ST_WAIT;
      cnt_q     <= '0;
      reload_q  <= '0;
      lo_hold_q <= '0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      gate_q    <= 1'b0;
      out_q     <= 1'b0;
    end else begin
      gate_q <= gate;
      if (cw_wr) begin
        mode_q  <= cw_mode;
        acc_q   <= cw_acc;
        st_q    <= ST_WAIT;
        out_q   <= (cw_mode != M_TERM);
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end else begin
        if (data_wr && acc_q == ACC_BOTH) begin
          wr_hi_q <= !wr_hi_q;
          if (!wr_hi_q) lo_hold_q <= wdata;
        end
        if (rd_stb && acc_q == ACC_BOTH) rd_hi_q <= !rd_hi_q;

        if (load_fire) begin
          reload_q <= new_count;
          case (mode_q)
            M_TERM: begin
              cnt_q <= new_count;
              out_q <= 1'b0;
              st_q  <= ST_RUN;
            end
            M_ONESHOT, M_HWSTB: begin
              if (st_q == ST_WAIT) st_q <= ST_ARMED;
            end
            M_RATE, M_SQUARE: begin
              if (st_q == ST_WAIT) begin
                cnt_q <= (mode_q == M_SQUARE) ? sq_high_len(new_count) : new_count;
                out_q <= 1'b1;
                st_q  <= ST_RUN;
              end
            end
            default: begin
              cnt_q <= new_count;
              out_q <= 1'b1;
              st_q  <= ST_RUN;
            end
          endcase
        end else if (retrig) begin
          cnt_q <= (mode_q == M_SQUARE) ? sq_high_len(reload_q) : reload_q;
          out_q <= (mode_q != M_ONESHOT);
          st_q  <= ST_RUN;
        end else if (advance) begin
          case (mode_q)
            M_RATE: begin
              if (cnt_q == CNT_W'(2)) out_q <= 1'b0;
              if (cnt_q == CNT_W'(1)) begin
                out_q <= 1'b1;
                cnt_q <= reload_q;
              end else begin
                cnt_q <= cnt_q - CNT_W'(1);
              end
            end
            M_SQUARE: begin
              if (cnt_q == CNT_W'(1)) begin
                out_q <= !out_q;
                cnt_q <= out_q ? sq_low_len(reload_q) : sq_high_len(reload_q);
              end else begin
                cnt_q <= cnt_q - CNT_W'(1);
              end
            end
            M_SWSTB, M_HWSTB: begin
              if (st_q == ST_STROBE) begin
                out_q <= 1'b1;
                st_q  <= ST_DONE;
              end else begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                  out_q <= 1'b0;
                  st_q  <= ST_STROBE;
                end
              end
            end
            default: begin
              cnt_q <= cnt_q - CNT_W'(1);
              if (cnt_q == CNT_W'(1)) begin
                out_q <= 1'b1;
                st_q  <= ST_DONE;
              end
            end
          endcase
        end else if (hold_high) begin
          out_q <= 1'b1;
        end
      end
    end
  end

  assign out     = out_q;
  assign rd_byte = (acc_q == ACC_HI || (acc_q == ACC_BOTH && rd_hi_q))
                   ? cnt_q[CNT_W-1:DATA_W] : cnt_q[DATA_W-1:0];

  // R3: a control byte parks the channel at its idle level
  assert_cw_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cw_wr |=> (st_q == ST_WAIT) && (out_q == (mode_q != M_TERM)));
  // R3: a waiting channel neither counts nor moves OUT
  assert_wait_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !load_fire && !cw_wr) |=> ($stable(cnt_q) && $stable(out_q)));
  // R5: a mode 0 load drives OUT low
  assert_term_load_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && mode_q == M_TERM && !cw_wr) |=> !out_q);
  // R6: a one-shot trigger drives OUT low
  assert_oneshot_trigger_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (retrig && mode_q == M_ONESHOT && !load_fire && !cw_wr) |=> !out_q);
  // R9: the strobe lasts exactly one counting tick
  assert_strobe_one_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STROBE && advance && !load_fire && !cw_wr) |=> out_q);
  // R13: GATE low holds periodic modes high and frozen
  assert_gate_low_high_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_high && !load_fire && !retrig && !cw_wr) |=> (out_q && $stable(cnt_q)));
endmodule

// File: rtl/pit_timer3.sv
module pit_timer3
  import pit_pkg::*;
#(
  parameter int CHANNELS = 3,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [CHANNELS-1:0] tick,
  input  logic [CHANNELS-1:0] gate,
  output logic [CHANNELS-1:0] out
);
  logic [CHANNELS-1:0] cw_wr, data_wr, rd_stb;
  logic [1:0]          cw_acc;
  logic [MODE_W-1:0]   cw_mode;
  logic [DATA_W-1:0]   rd_bytes [CHANNELS];

  pit_decode #(.CHANNELS(CHANNELS), .ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .cw_field(wdata[DATA_W-1:1]), .cw_wr(cw_wr), .data_wr(data_wr),
    .rd_stb(rd_stb), .cw_acc(cw_acc), .cw_mode(cw_mode)
  );

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
    pit_channel u_chan (
      .clk(clk), .rst_n(rst_n), .cw_wr(cw_wr[i]), .cw_acc(cw_acc),
      .cw_mode(cw_mode), .data_wr(data_wr[i]), .rd_stb(rd_stb[i]),
      .wdata(wdata), .tick(tick[i]), .gate(gate[i]), .out(out[i]),
      .rd_byte(rd_bytes[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < CHANNELS; i++)
      if (rd_en && addr == ADDR_W'(i)) rdata = rd_bytes[i];
  end
endmodule

// File: tb/test_pit_timer3.sv
module test_pit_timer3;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic [2:0] tick, gate, out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pit_timer3 i_pit_timer3 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick(tick), .gate(gate), .out(out)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] n;
    logic        lvl;
    logic [15:0] e1;
    logic [15:0] e2;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 16'd5, 1'b0, 16'd5, 16'd300},
    '{3'd1, 16'd3, 1'b0, 16'd3, 16'd300},
    '{3'd2, 16'd4, 1'b1, 16'd3, 16'd1},
    '{3'd2, 16'd7, 1'b1, 16'd6, 16'd1},
    '{3'd3, 16'd4, 1'b1, 16'd2, 16'd2},
    '{3'd3, 16'd5, 1'b1, 16'd3, 16'd2},
    '{3'd3, 16'd9, 1'b1, 16'd5, 16'd4},
    '{3'd4, 16'd3, 1'b1, 16'd3, 16'd1},
    '{3'd5, 16'd3, 1'b1, 16'd3, 16'd1},
    '{3'd5, 16'd6, 1'b1, 16'd6, 16'd1}
  };

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic run_len(input int ch, input logic lvl, input int maxn, output int n);
    n = 0;
    while (out[ch] == lvl && n < maxn) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n1, n2;
    logic [7:0] b;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    tick = 3'b111; gate = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3", "reset OUT", int'(out), 0);
    check("R3", "idle rdata", int'(rdata), 0);

    // Table walk on channel 0, two-byte transfer
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      bit edge_start;
      v = VEC[k];
      edge_start = (v.mode == 3'd1 || v.mode == 3'd5);
      gate[0] = !edge_start;
      wr(2'd3, {2'b00, 2'b11, v.mode, 1'b0});
      wr(2'd0, v.n[7:0]);
      wr(2'd0, v.n[15:8]);
      if (edge_start) begin
        gate[0] = 1'b1;
        @(negedge clk);
      end
      run_len(0, v.lvl, 300, n1);
      run_len(0, !v.lvl, 300, n2);
      check(req_of(v.mode), "first run", n1, int'(v.e1));
      check(req_of(v.mode), "second run", n2, int'(v.e2));
      gate[0] = 1'b0;
    end

    // R1 R4: 36H, count held until high byte
    gate[0] = 1'b1;
    wr(2'd3, 8'h36);
    check("R3", "ch0 idle after 36H", int'(out[0]), 1);
    wr(2'd0, 8'h04);
    run_len(0, 1'b1, 6, n1);
    check("R4", "no start on low byte", n1, 6);
    wr(2'd0, 8'h00);
    run_len(0, 1'b1, 50, n1);
    run_len(0, 1'b0, 50, n2);
    check("R1", "36H high half", n1, 2);
    check("R1", "36H low half", n2, 2);

    // R1 R4: 54H, low byte only
    gate[1] = 1'b1;
    wr(2'd3, 8'h54);
    wr(2'd1, 8'h05);
    run_len(1, 1'b1, 50, n1);
    run_len(1, 1'b0, 50, n2);
    check("R1", "54H high part", n1, 4);
    check("R4", "54H low part", n2, 1);

    // R1 R8: B6H, odd count
    gate[2] = 1'b1;
    wr(2'd3, 8'hB6);
    wr(2'd2, 8'h03);
    wr(2'd2, 8'h00);
    run_len(2, 1'b1, 50, n1);
    run_len(2, 1'b0, 50, n2);
    check("R8", "odd high half", n1, 2);
    check("R1", "odd low half", n2, 1);

    // R2: reserved channel field and latch code leave channel 1 running
    wr(2'd3, 8'hD4);
    wr(2'd3, 8'h44);
    run_len(1, 1'b1, 50, n1);
    run_len(1, 1'b0, 50, n2);
    check("R2", "ch1 low after ignored bytes", n2, 1);
    run_len(1, 1'b1, 50, n1);
    check("R2", "ch1 high after ignored bytes", n1, 4);

    // R13: GATE low forces OUT high, rising edge restarts
    gate[1] = 1'b0;
    @(negedge clk);
    run_len(1, 1'b1, 10, n1);
    check("R13", "gate low holds high", n1, 10);
    gate[1] = 1'b1;
    @(negedge clk);
    run_len(1, 1'b1, 50, n1);
    check("R7", "restart after gate rise", n1, 4);

    // R4 R3: high-only transfer in mode 0
    wr(2'd3, 8'hA0);
    check("R3", "mode 0 idle low", int'(out[2]), 0);
    wr(2'd2, 8'h01);
    run_len(2, 1'b0, 400, n1);
    check("R4", "high-only count 256", n1, 256);

    // R12 R13: read live count, GATE and tick halt
    gate[1] = 1'b0;
    wr(2'd3, 8'h70);
    wr(2'd1, 8'h34);
    wr(2'd1, 8'h12);
    repeat (5) @(negedge clk);
    rd(2'd1, b); check("R12", "low byte", int'(b), 8'h34);
    rd(2'd1, b); check("R12", "high byte", int'(b), 8'h12);
    check("R5", "mode 0 still low", int'(out[1]), 0);
    gate[1] = 1'b1; tick[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd1, b); check("R13", "no tick low byte", int'(b), 8'h34);
    rd(2'd1, b); check("R13", "no tick high byte", int'(b), 8'h12);
    tick[1] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(2'd1, b); check("R12", "live low byte", int'(b), 8'h31);
    rd(2'd1, b); check("R12", "live high byte", int'(b), 8'h12);

    // R11: zero count is 65536
    gate[0] = 1'b1;
    wr(2'd3, 8'h10);
    wr(2'd0, 8'h00);
    run_len(0, 1'b0, 70000, n1);
    check("R11", "zero count low span", n1, 65536);

    // R6: retrigger during the pulse
    gate[2] = 1'b0;
    wr(2'd3, 8'hB2);
    wr(2'd2, 8'h05);
    wr(2'd2, 8'h00);
    check("R6", "armed high", int'(out[2]), 1);
    gate[2] = 1'b1;
    @(negedge clk);
    check("R6", "triggered low", int'(out[2]), 0);
    gate[2] = 1'b0;
    @(negedge clk);
    gate[2] = 1'b1;
    run_len(2, 1'b0, 50, n1);
    check("R6", "retriggered low span", n1, 6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule